// File: doc/BRIEF.md
# Configurable GPIO Bank with Per-Pin Drive Mode

This block is a single bank of up to eight general-purpose pins sitting behind a byte-wide configuration port. A host selects a logical device number and then addresses a byte index. When the device number matches and the index falls inside the bank's four-byte window, the block answers. The window holds four registers: pin direction, output level, sampled input level and drive style.

Each pin can be an input or an output. An output pin is either push-pull, where it always drives the stored level, or open-drain, where it only pulls low and otherwise floats. The block produces an output-enable and an output value per pin for an external pad model. It returns the pad levels through a two-stage synchroniser. The window position and the pin count are parameters. Register bits above the pin count do not exist.

Top module: `gpio_bank_drv`

## Requirements
- R1: After reset every pin is an input, the output-level and drive-style registers hold 0 (all pins open-drain), and pad_oe and pad_out are all 0.
- R2: The bank answers only when ld_sel equals DEV_NUM and cfg_idx lies in BANK_BASE to BANK_BASE+3. Any other access reads 0 and a write to it changes no register.
- R3: Byte offset 0 is the direction register. Bit p = 1 makes pin p an output and 0 makes it an input; the register reads back as written.
- R4: Byte offset 1 is the output-level register and reads back as written. Writing it while the pin is an input leaves the pad undriven, and a later switch to output drives that level at once.
- R5: Byte offset 3 is the drive-style register. Bit p = 1 selects push-pull and 0 selects open-drain; it reads back as written.
- R6: A push-pull output pin has pad_oe = 1 and pad_out equal to its output-level bit.
- R7: An open-drain output pin has pad_oe = 1 and pad_out = 0 when its level bit is 0, and pad_oe = 0 and pad_out = 0 when its level bit is 1.
- R8: An input pin has pad_oe = 0 and pad_out = 0, whatever its level and drive-style bits hold.
- R9: Byte offset 2 returns pin_in through two flops: a level applied before rising edge k reads back from just after edge k+1. Writes to offset 2 are ignored.
- R10: Register bits at or above NUM_PINS read as 0 and ignore writes.
- R11: A write takes effect on the rising edge that samples cfg_wr high, and the pads change directly after that edge, not before it.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_sel | input | 8 | Currently selected logical device number |
| cfg_idx | input | 8 | Configuration byte index |
| cfg_wr | input | 1 | Write strobe for cfg_wdata at cfg_idx |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_idx (combinational) |
| pin_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pad_oe | output | NUM_PINS | Per-pin output enable |
| pad_out | output | NUM_PINS | Per-pin driven value |

## Verification
A configuration write and a new pad level entering the synchroniser can land on the same rising edge. The bench changes pin_in and writes the direction register in one cycle. It then checks that the pads follow the new direction right after that edge. It also checks that the input register still shows the old level for one more cycle and the new level only after the second edge. The drive behaviour is swept over every direction and level pattern of a five-pin bank under several drive-style patterns, and the expected pads are computed bit by bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned GB_REG_W   = 8;
   localparam int unsigned GB_WIN     = 4;
   localparam int unsigned GB_OFS_W   = $clog2(GB_WIN);

   typedef enum logic [GB_OFS_W-1:0] {
      OFS_DIR  = 2'd0,
      OFS_DOUT = 2'd1,
      OFS_DIN  = 2'd2,
      OFS_MODE = 2'd3
   } gb_ofs_e;
endpackage

// File: rtl/gpio_bank_dec.sv
module gpio_bank_dec
   import gpio_bank_pkg::*;
#(
   parameter logic [GB_REG_W-1:0] BANK_BASE = 8'hF0,
   parameter logic [GB_REG_W-1:0] DEV_NUM   = 8'h06
) (
   input  logic [GB_REG_W-1:0] ld_sel,
   input  logic [GB_REG_W-1:0] cfg_idx,
   output logic                hit,
   output gb_ofs_e             ofs
);
   logic dev_match;
   logic win_match;

   assign dev_match = (ld_sel == DEV_NUM);
   assign win_match = (cfg_idx[GB_REG_W-1:GB_OFS_W] == BANK_BASE[GB_REG_W-1:GB_OFS_W]);
   assign hit       = dev_match && win_match;
   assign ofs       = gb_ofs_e'(cfg_idx[GB_OFS_W-1:0]);
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NUM_PINS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  gb_ofs_e             ofs,
   input  logic [GB_REG_W-1:0] wdata,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] dout_q,
   output logic [NUM_PINS-1:0] mode_q
);
   logic [NUM_PINS-1:0] wbits;

   assign wbits = wdata[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         dout_q <= '0;
         mode_q <= '0;
      end else if (wr_en) begin
         case (ofs)
            OFS_DIR:  dir_q  <= wbits;
            OFS_DOUT: dout_q <= wbits;
            OFS_MODE: mode_q <= wbits;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] sync_q
);
   logic [NUM_PINS-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [NUM_PINS-1:0] d;
      if (s == 0) begin : g_first
         assign d = pin_in;
      end else begin : g_next
         assign d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= d;
      end
   end

   assign sync_q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_drive.sv
module gpio_bank_drive #(
   parameter int unsigned NUM_PINS = 8
) (
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic [NUM_PINS-1:0] dout_q,
   input  logic [NUM_PINS-1:0] mode_q,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out
);
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic oe_l;
      logic val_l;
      always_comb begin
         if (!dir_q[p]) begin
            oe_l  = 1'b0;
            val_l = 1'b0;
         end else if (mode_q[p]) begin
            oe_l  = 1'b1;
            val_l = dout_q[p];
         end else begin
            oe_l  = ~dout_q[p];
            val_l = 1'b0;
         end
      end
      assign pad_oe[p]  = oe_l;
      assign pad_out[p] = val_l;
   end
endmodule

// File: rtl/gpio_bank_drv.sv
module gpio_bank_drv
   import gpio_bank_pkg::*;
#(
   parameter logic [7:0]  BANK_BASE   = 8'hF0,
   parameter logic [7:0]  DEV_NUM     = 8'h06,
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [7:0]          ld_sel,
   input  logic [7:0]          cfg_idx,
   input  logic                cfg_wr,
   input  logic [7:0]          cfg_wdata,
   output logic [7:0]          cfg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out
);
   if (NUM_PINS < 1 || NUM_PINS > GB_REG_W) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..8");
   end
   if (BANK_BASE[GB_OFS_W-1:0] != '0) begin : g_bad_base
      $error("BANK_BASE must be aligned to the four-byte window");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                dec_hit;
   gb_ofs_e             dec_ofs;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] dout_q;
   logic [NUM_PINS-1:0] mode_q;
   logic [NUM_PINS-1:0] din_q;
   logic [GB_REG_W-1:0] rd_mux;

   gpio_bank_dec #(.BANK_BASE(BANK_BASE), .DEV_NUM(DEV_NUM)) u_dec (
      .ld_sel (ld_sel),
      .cfg_idx(cfg_idx),
      .hit    (dec_hit),
      .ofs    (dec_ofs)
   );

   gpio_bank_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_wr && dec_hit),
      .ofs   (dec_ofs),
      .wdata (cfg_wdata),
      .dir_q (dir_q),
      .dout_q(dout_q),
      .mode_q(mode_q)
   );

   gpio_bank_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_in(pin_in),
      .sync_q(din_q)
   );

   gpio_bank_drive #(.NUM_PINS(NUM_PINS)) u_drive (
      .dir_q  (dir_q),
      .dout_q (dout_q),
      .mode_q (mode_q),
      .pad_oe (pad_oe),
      .pad_out(pad_out)
   );

   always_comb begin
      rd_mux = '0;
      if (dec_hit) begin
         case (dec_ofs)
            OFS_DIR:  rd_mux[NUM_PINS-1:0] = dir_q;
            OFS_DOUT: rd_mux[NUM_PINS-1:0] = dout_q;
            OFS_DIN:  rd_mux[NUM_PINS-1:0] = din_q;
            OFS_MODE: rd_mux[NUM_PINS-1:0] = mode_q;
            default:  rd_mux = '0;
         endcase
      end
   end

   assign cfg_rdata = rd_mux;
endmodule

// File: rtl/gpio_bank_drv_chk.sv
module gpio_bank_drv_chk #(
   parameter int unsigned NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [7:0]          cfg_idx,
   input logic                cfg_wr,
   input logic [7:0]          cfg_rdata,
   input logic [NUM_PINS-1:0] pin_in,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] dir_q,
   input logic [NUM_PINS-1:0] dout_q,
   input logic [NUM_PINS-1:0] mode_q,
   input logic                dec_hit
);
   localparam logic [7:0] IMPL_MASK = 8'((16'd1 << NUM_PINS) - 16'd1);

   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age_q <= '0;
      else if (age_q != 2'd2) age_q <= age_q + 2'd1;
   end

   AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_hit |-> (cfg_rdata == 8'h00)); // R2

   AST_MISS_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !dec_hit) |=> ($stable(dir_q) && $stable(dout_q) && $stable(mode_q))); // R2

   AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~dir_q) == '0)); // R8

   AST_VALUE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & ~pad_oe) == '0)); // R7

   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_rdata & ~IMPL_MASK) == 8'h00)); // R10

   AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2 && dec_hit && cfg_idx[1:0] == 2'd2)
         |-> (cfg_rdata[NUM_PINS-1:0] == $past(pin_in, 2))); // R9
endmodule

bind gpio_bank_drv gpio_bank_drv_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_idx  (cfg_idx),
   .cfg_wr   (cfg_wr),
   .cfg_rdata(cfg_rdata),
   .pin_in   (pin_in),
   .pad_oe   (pad_oe),
   .pad_out  (pad_out),
   .dir_q    (dir_q),
   .dout_q   (dout_q),
   .mode_q   (mode_q),
   .dec_hit  (dec_hit)
);

// File: tb/gpio_bank_drv_tb.sv
module gpio_bank_drv_tb;
   localparam int         CLK_PERIOD = 10;
   localparam int         NP         = 5;
   localparam logic [7:0] BASE       = 8'hA0;
   localparam logic [7:0] LDN        = 8'h06;
   localparam logic [7:0] MASK       = 8'h1F;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    ld_sel = LDN;
   logic [7:0]    cfg_idx = 8'h00;
   logic          cfg_wr = 1'b0;
   logic [7:0]    cfg_wdata = 8'h00;
   logic [7:0]    cfg_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pad_oe;
   logic [NP-1:0] pad_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank_drv #(.BANK_BASE(BASE), .DEV_NUM(LDN), .NUM_PINS(NP)) u_dut (
      .clk(clk), .rst_n(rst_n), .ld_sel(ld_sel), .cfg_idx(cfg_idx),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] idx, logic [7:0] val);
      @(negedge clk);
      cfg_idx = idx; cfg_wdata = val; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      #1;
   endtask

   task automatic rd(logic [7:0] idx, output logic [7:0] val);
      cfg_idx = idx;
      #1;
      val = cfg_rdata;
   endtask

   function automatic logic [NP-1:0] exp_oe(logic [NP-1:0] d, logic [NP-1:0] o, logic [NP-1:0] m);
      return d & (m | ~o);
   endfunction

   function automatic logic [NP-1:0] exp_out(logic [NP-1:0] d, logic [NP-1:0] o, logic [NP-1:0] m);
      return d & m & o;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [NP-1:0] ed, eo, em, prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 oe", 32'(pad_oe), 0);
      check("R1 out", 32'(pad_out), 0);
      for (int k = 0; k < 4; k++) begin
         rd(BASE + 8'(k), v);
         check("R1 reg", 32'(v), 0);
      end
      // R4 preload level while input
      wr(BASE + 8'd1, 8'h0B);
      check("R4 undriven", 32'(pad_oe), 0);
      rd(BASE + 8'd1, v);
      check("R4 readback", 32'(v), 32'h0B);
      // R10/R5 upper bits absent
      wr(BASE + 8'd3, 8'hFF);
      rd(BASE + 8'd3, v);
      check("R10 mode mask", 32'(v), 32'(MASK));
      // R11 write not visible before the edge
      @(negedge clk);
      cfg_idx = BASE; cfg_wdata = 8'hFF; cfg_wr = 1'b1;
      #1;
      check("R11 before edge", 32'(pad_oe), 0);
      @(negedge clk);
      cfg_wr = 1'b0;
      #1;
      check("R4 level on switch", 32'(pad_out), 32'h0B);
      check("R11 after edge", 32'(pad_oe), 32'h1F);
      rd(BASE, v);
      check("R10 dir mask", 32'(v), 32'(MASK));

      // R3 R5 R6 R7 R8 sweep
      for (int mi = 0; mi < 4; mi++) begin
         em = (mi == 0) ? 5'h00 : (mi == 1) ? 5'h1F : (mi == 2) ? 5'h15 : 5'h0A;
         wr(BASE + 8'd3, 8'(em));
         rd(BASE + 8'd3, v);
         check("R5 readback", 32'(v), 32'(em));
         for (int d = 0; d < 32; d++) begin
            wr(BASE, 8'(d));
            ed = NP'(d);
            for (int o = 0; o < 32; o++) begin
               wr(BASE + 8'd1, 8'(o));
               eo = NP'(o);
               check("R6 R7 R8 oe", 32'(pad_oe), 32'(exp_oe(ed, eo, em)));
               check("R6 R7 R8 out", 32'(pad_out), 32'(exp_out(ed, eo, em)));
            end
            rd(BASE, v);
            check("R3 readback", 32'(v), 32'(ed));
         end
      end

      // R2 decode sweep
      wr(BASE, 8'h15); wr(BASE + 8'd1, 8'h0A); wr(BASE + 8'd3, 8'h13);
      @(negedge clk); pin_in = 5'h09;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 256; i++) begin
         logic [7:0] e;
         rd(8'(i), v);
         if (8'(i) == BASE)             e = 8'h15;
         else if (8'(i) == BASE + 8'd1) e = 8'h0A;
         else if (8'(i) == BASE + 8'd2) e = 8'h09;
         else if (8'(i) == BASE + 8'd3) e = 8'h13;
         else                           e = 8'h00;
         check("R2 read decode", 32'(v), 32'(e));
      end
      ld_sel = 8'h05;
      for (int k = 0; k < 4; k++) begin
         rd(BASE + 8'(k), v);
         check("R2 wrong device read", 32'(v), 0);
         wr(BASE + 8'(k), 8'hFF);
      end
      ld_sel = LDN;
      for (int i = 0; i < 256; i++) begin
         if (8'(i) < BASE || 8'(i) > BASE + 8'd3) wr(8'(i), 8'hFF);
      end
      rd(BASE, v);         check("R2 dir held", 32'(v), 32'h15);
      rd(BASE + 8'd1, v);  check("R2 data held", 32'(v), 32'h0A);
      rd(BASE + 8'd3, v);  check("R2 mode held", 32'(v), 32'h13);
      check("R2 pads held", 32'(pad_oe), 32'(exp_oe(5'h15, 5'h0A, 5'h13)));
      // R9 write to input register ignored
      wr(BASE + 8'd2, 8'hFF);
      rd(BASE + 8'd2, v);
      check("R9 input write ignored", 32'(v), 32'h09);

      // R9 synchroniser latency sweep
      prev = 5'h09;
      for (int p = 0; p < 32; p++) begin
         @(negedge clk); pin_in = NP'(p);
         @(negedge clk); rd(BASE + 8'd2, v);
         check("R9 one edge", 32'(v), 32'(prev));
         @(negedge clk); rd(BASE + 8'd2, v);
         check("R9 two edges", 32'(v), 32'(p));
         prev = NP'(p);
      end

      // R11 with R9: write and pin change on the same edge
      wr(BASE + 8'd3, 8'h1F);
      wr(BASE, 8'h00);
      @(negedge clk);
      pin_in = 5'h1A;
      cfg_idx = BASE; cfg_wdata = 8'h07; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      #1;
      check("R11 same edge oe", 32'(pad_oe), 32'h07);
      rd(BASE + 8'd2, v);
      check("R9 same edge old level", 32'(v), 32'(prev));
      @(negedge clk);
      rd(BASE + 8'd2, v);
      check("R9 same edge new level", 32'(v), 32'h1A);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule